// File: doc/BRIEF.md
# Successive-Approximation Converter Serial Interface Model

This block models the digital side of a serial-output successive-approximation converter. It runs entirely on the incoming serial clock. When chip select goes low, the track/hold control switches to hold at once and a frame starts. Every falling serial clock edge after that advances the frame by one position. The first few positions put zeros on the wire. The following positions each try one bit of the result, from the most significant bit down. The block drives the trial code to an external DAC, reads back a one-bit comparator answer, and keeps or drops that bit at the falling edge. The bit it keeps goes onto the serial data line on that same edge. Trailing zeros follow the result, and after that the line floats.

The comparator and all analog parts sit outside the block. A testbench or a mixed-signal model holds the analog input, compares it against the trial code and returns the answer. Chip select going high at any point floats the line and releases the hold at once. The frame state is then cleared at the next falling clock edge, so the next low-going chip select always begins a new conversion. The chip-select low time must span at least one falling clock edge between frames.

Top module: `sar_serial_model`

## Requirements
- R1: While `rstN` is low, `sdata` is high impedance, `sdataOe` and `trackHold` are 0, and `dacCode` is 0.
- R2: When `csN` goes low, `trackHold` goes to 1 (hold) and `sdataOe` goes to 1 with no clock edge needed. For the first 4 frame positions (before the 4th falling `sclk` edge) `sdata` carries 0.
- R3: Frame positions 3 to 18 are the trial steps. Position p counts the falling `sclk` edges seen with `csN` low. At step p, `dacCode` holds the bits already decided, with bit 18-p set and all lower bits 0. At the falling edge that ends the step, that bit keeps the value of `cmpIn`. `cmpIn`=1 means the input is at or above the trial level.
- R4: At positions 4 to 19, `sdata` carries result bit 19-p, most significant bit first. Each bit appears right after the falling edge that decided it. The complete result is the straight binary code of the input, with full scale at all ones.
- R5: `trackHold` returns to 0 (track) at the falling edge that decides the least significant bit, which is the 19th falling edge of the frame.
- R6: Positions 20 to 23 carry 0. After the 24th falling edge, `sdata` is high impedance and `sdataOe` is 0 for as long as `csN` stays low.
- R7: A rising `csN` makes `sdata` high impedance and `trackHold` 0 at once. It aborts any conversion in progress, and the frame and the result are cleared at the next falling `sclk` edge. The next low-going `csN` starts a fresh frame from position 0.
- R8: Before the first trial step, `dacCode` is 0. After the last step it holds the finished result until `csN` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; also paces the conversion |
| csN | input | 1 | Active-low chip select; starts the frame and frames the transfer |
| cmpIn | input | 1 | Comparator answer: 1 when the input is at or above `dacCode` |
| sdata | output | 1 | Three-state serial data output |
| sdataOe | output | 1 | 1 while `sdata` is driven |
| dacCode | output | 16 | Trial code presented to the external DAC |
| trackHold | output | 1 | 1 = hold, 0 = track |

## Verification
The assertions check properties on every falling edge. The decided bit must equal the comparator answer from the step before. The first trial code must be the most significant bit alone. Padding positions must drive zeros. The frame must clear one edge after chip select goes high, and hold must drop after the last step. Other behaviour only shows up in the bench's scenarios, which compare every cycle against an independent behavioural model. This covers the exact serial stream for all-zero, all-one, mid-scale and mixed codes. It covers the line floating during a long chip-select low time. It also covers a conversion aborted part-way and followed by a clean one, and a frame cut short right after the last data bit.

// File: rtl/sar_serial_pkg.sv
package sar_serial_pkg;

  // Per-edge strobes handed from the frame control to the datapath
  typedef struct packed {
    logic clear;      // chip select high: wipe the result
    logic decide;     // a trial step ends at this falling edge
    logic trialOn;    // a trial bit is presented on the DAC code
    logic dataPhase;  // the wire carries a result bit
  } sar_strobe_t;

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_serial_pkg::*;
#(
  parameter int RES   = 16,
  parameter int LEAD  = 4,
  parameter int TRAIL = 4
) (
  input  logic                    sclk,
  input  logic                    rstN,
  input  logic                    csN,
  output sar_strobe_t             strobe,
  output logic [$clog2(RES)-1:0]  stepIdx,
  output logic [$clog2(RES)-1:0]  outIdx,
  output logic                    oe,
  output logic                    hold
);
  localparam int FRAME = LEAD + RES + TRAIL;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam int IDX_W = $clog2(RES);

  localparam logic [CNT_W-1:0] FRAME_C     = CNT_W'(FRAME);
  localparam logic [CNT_W-1:0] STEP_FIRST  = CNT_W'(LEAD - 1);
  localparam logic [CNT_W-1:0] STEP_END    = CNT_W'(LEAD - 1 + RES);
  localparam logic [CNT_W-1:0] DATA_FIRST  = CNT_W'(LEAD);
  localparam logic [CNT_W-1:0] DATA_END    = CNT_W'(LEAD + RES);
  localparam logic [CNT_W-1:0] STEP_BASE   = CNT_W'(LEAD + RES - 2);
  localparam logic [CNT_W-1:0] OUT_BASE    = CNT_W'(LEAD + RES - 1);

  logic [CNT_W-1:0] cnt;
  logic             inStep;
  logic             inData;

  always_ff @(negedge sclk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (csN)          cnt <= '0;
    else if (cnt < FRAME_C) cnt <= cnt + 1'b1;
  end

  assign inStep = (cnt >= STEP_FIRST) && (cnt < STEP_END);
  assign inData = (cnt >= DATA_FIRST) && (cnt < DATA_END);

  always_comb begin
    strobe.clear     = csN;
    strobe.decide    = !csN && inStep;
    strobe.trialOn   = !csN && inStep;
    strobe.dataPhase = !csN && inData;
  end

  assign stepIdx = IDX_W'(STEP_BASE - cnt);
  assign outIdx  = IDX_W'(OUT_BASE - cnt);
  assign oe      = rstN && !csN && (cnt < FRAME_C);
  assign hold    = rstN && !csN && (cnt < STEP_END);

  // R7: a high chip select wipes the frame by the next falling edge
  p_abort_clear_r7: assert property (@(negedge sclk) disable iff (!rstN)
    csN |=> (cnt == '0));

  // R5: after the last trial edge the hold is released
  p_hold_release_r5: assert property (@(negedge sclk) disable iff (!rstN)
    (!csN && cnt == STEP_END - 1'b1) |=> (!hold || csN));

  // R6: the frame position never runs past the frame length
  p_frame_bound_r6: assert property (@(negedge sclk) disable iff (!rstN)
    (cnt == FRAME_C) |=> (cnt == FRAME_C || cnt == '0));

endmodule

// File: rtl/sar_dp.sv
module sar_dp
  import sar_serial_pkg::*;
#(
  parameter int RES = 16
) (
  input  logic                    sclk,
  input  logic                    rstN,
  input  sar_strobe_t             strobe,
  input  logic [$clog2(RES)-1:0]  stepIdx,
  input  logic [$clog2(RES)-1:0]  outIdx,
  input  logic                    cmpIn,
  output logic [RES-1:0]          dacCode,
  output logic                    dataBit
);
  localparam logic [RES-1:0] ONE_HOT0 = RES'(1);
  localparam logic [RES-1:0] MSB_ONLY = ONE_HOT0 << (RES - 1);

  logic [RES-1:0] result;
  logic [RES-1:0] trialMask;

  assign trialMask = ONE_HOT0 << stepIdx;

  always_ff @(negedge sclk or negedge rstN) begin
    if (!rstN)              result <= '0;
    else if (strobe.clear)  result <= '0;
    else if (strobe.decide) result[stepIdx] <= cmpIn;
  end

  assign dacCode = strobe.trialOn ? (result | trialMask) : result;
  assign dataBit = strobe.dataPhase ? result[outIdx] : 1'b0;

  // R3: the first trial presents the top bit alone
  p_first_trial_r3: assert property (@(negedge sclk) disable iff (!rstN)
    (strobe.decide && stepIdx == $clog2(RES)'(RES - 1)) |-> (dacCode == MSB_ONLY));

  // R3: the decided bit holds the comparator answer of its step
  p_keep_bit_r3: assert property (@(negedge sclk) disable iff (!rstN)
    strobe.decide |=> (result[$past(stepIdx)] == $past(cmpIn)));

endmodule

// File: rtl/sar_serial_model.sv
module sar_serial_model
  import sar_serial_pkg::*;
#(
  parameter int RES   = 16,
  parameter int LEAD  = 4,
  parameter int TRAIL = 4
) (
  input  logic           rstN,
  input  logic           sclk,
  input  logic           csN,
  input  logic           cmpIn,
  output logic           sdata,
  output logic           sdataOe,
  output logic [RES-1:0] dacCode,
  output logic           trackHold
);
  localparam int IDX_W = $clog2(RES);

  sar_strobe_t      strobe;
  logic [IDX_W-1:0] stepIdx;
  logic [IDX_W-1:0] outIdx;
  logic             dataBit;

  sar_ctrl #(.RES(RES), .LEAD(LEAD), .TRAIL(TRAIL)) u_ctrl (
    .sclk    (sclk),
    .rstN    (rstN),
    .csN     (csN),
    .strobe  (strobe),
    .stepIdx (stepIdx),
    .outIdx  (outIdx),
    .oe      (sdataOe),
    .hold    (trackHold)
  );

  sar_dp #(.RES(RES)) u_dp (
    .sclk    (sclk),
    .rstN    (rstN),
    .strobe  (strobe),
    .stepIdx (stepIdx),
    .outIdx  (outIdx),
    .cmpIn   (cmpIn),
    .dacCode (dacCode),
    .dataBit (dataBit)
  );

  assign sdata = sdataOe ? dataBit : 1'bz;

  // R2 / R6: padding positions drive zero
  p_pad_zero_r2: assert property (@(negedge sclk) disable iff (!rstN)
    (sdataOe && !strobe.dataPhase) |-> !dataBit);

  // R7: no drive while chip select is high
  p_float_r7: assert property (@(negedge sclk) disable iff (!rstN)
    csN |-> (!sdataOe && !trackHold));

endmodule

// File: tb/sar_serial_model_bench.sv
`timescale 1ns/1ps
module sar_serial_model_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic [15:0] vin = '0;
  logic        cmpIn;
  wire         sdata;
  logic        sdataOe;
  logic [15:0] dacCode;
  logic        trackHold;

  int checks = 0;
  int errors = 0;
  int idx = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign cmpIn = (vin >= dacCode);

  sar_serial_model u_sar_serial_model (
    .rstN(rstN), .sclk(clk), .csN(csN), .cmpIn(cmpIn),
    .sdata(sdata), .sdataOe(sdataOe), .dacCode(dacCode), .trackHold(trackHold)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference: frame position counted on falling edges
  always @(negedge clk) begin
    if (!rstN || csN) idx <= 0;
    else if (idx < 24) idx <= idx + 1;
  end

  // compare on every rising edge (inputs move 1 ns later)
  always @(posedge clk) begin
    if (rstN && !done) begin
      bit expOe, expBit, expHold;
      int expDac, k;
      expOe   = !csN && idx < 24;
      expHold = !csN && idx < 19;
      expBit  = (idx >= 4 && idx < 20) ? vin[19 - idx] : 1'b0;
      check(sdataOe == expOe, "R6/R7", "sdataOe", int'(sdataOe), int'(expOe));
      check(trackHold == expHold, "R5/R2", "trackHold", int'(trackHold), int'(expHold));
      if (expOe)
        check(sdata === expBit, "R4/R2", "sdata", int'(sdata), int'(expBit));
      else
        check(sdata === 1'bz, "R6", "sdata float", int'(sdata === 1'bz), 1);
      if (!csN) begin
        if (idx < 3) expDac = 0;
        else if (idx < 19) begin
          k = idx - 3;
          expDac = ((int'(vin) >> (16 - k)) << (16 - k)) | (1 << (15 - k));
        end else expDac = int'(vin);
        check(int'(dacCode) == expDac, "R3/R8", "dacCode", int'(dacCode), expDac);
      end
    end
  end

  task automatic frame(input logic [15:0] value, input int lowClocks);
    @(posedge clk); #1;
    vin = value;
    csN = 1'b0;
    repeat (lowClocks) @(posedge clk);
    #1 csN = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // R1: reset state
    check(sdata === 1'bz, "R1", "sdata in reset", int'(sdata === 1'bz), 1);
    check(!sdataOe, "R1", "sdataOe in reset", int'(sdataOe), 0);
    check(!trackHold, "R1", "trackHold in reset", int'(trackHold), 0);
    check(dacCode == 16'h0, "R1", "dacCode in reset", int'(dacCode), 0);
    #1 rstN = 1'b1;
    repeat (2) @(posedge clk);
    frame(16'h0000, 26);   // R4 all zeros
    frame(16'hFFFF, 30);   // R4 full scale, R6 long low time floats
    frame(16'h8000, 26);   // R3 mid-scale
    frame(16'h7FFF, 26);
    frame(16'hA5C3, 26);
    frame(16'h1234, 10);   // R7 abort mid-conversion
    frame(16'hBEEF, 26);   // R7 fresh frame afterwards
    frame(16'h5A5A, 20);   // R7 cut short after last data bit
    frame(16'h0001, 25);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule